// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register file that software uses to drive an SMBus host controller. Through a small synchronous register bus it holds status, control, command, target address, two data bytes, a block-data port and an auxiliary mode register. It turns control writes into launch pulses for a separate transaction engine, and it collects done, device-error and byte-done events from that engine into a status byte. Status bits are cleared by writing ones, and an interrupt line is raised while interrupts are enabled and any status bit other than busy is set.

Two start modes exist. When interrupt enable is set, a start request launches the engine in the cycle after the write. When interrupt enable is clear, the start is held back: busy rises, and the engine is only launched when software next reads the status register. That read returns the status as it was before the launch. In block-buffer mode, block-data accesses are handed to an external buffer at a running index. A kill request aborts the pending work.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset the status, control, command, address, data and block-data registers read 0x00, the block index is 0, irq_o is low, and the auxiliary register reads back {force_blk_i, 0} in bits 1:0.
- R2: Writing the status register (offset 0x00) clears each of bits 7:1 written as 1. Bit 0 (busy) is never cleared this way. An engine event that sets a bit wins over a clear in the same cycle: done sets bit 1, device error sets bit 2 and byte done sets bit 7.
- R3: Control (offset 0x02) reads back only bits 4:0, and start (bit 6) is never stored. Command (0x03), address (0x04), data0 (0x05) and data1 (0x06) read back what was written. Auxiliary (0x0D) keeps only bits 1:0. Every other offset reads 0x00.
- R4: A control write with start (bit 6) and interrupt enable (bit 0) both set pulses xact_start_o high for exactly the next cycle and leaves busy unchanged.
- R5: A control write with start set and interrupt enable clear sets busy and does not pulse xact_start_o. The next status read returns the status with busy still 1, then clears busy and pulses xact_start_o in the following cycle.
- R6: No launch pulse is produced, whether immediate or deferred, while the device-error bit (bit 2) is set at the moment of launch.
- R7: A control write with kill (bit 1) set sets failed (bit 4), clears busy, cancels any deferred start and zeroes the block index.
- R8: irq_o is high exactly when control bit 0 is 1 and any of status bits 7:1 is 1.
- R9: With auxiliary bit 1 set (block-buffer mode), a block-data write (offset 0x07) pulses blk_wr_o at the current index, and a block-data read returns blk_rdata_i and pulses blk_rd_o. Both advance the index by one. With bit 1 clear, block data is a plain local byte and the index does not move.
- R10: The block index wraps from 2^IDX_W-1 to 0, and any control write with start set zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_blk_i | input | 1 | Strap: block-buffer mode on after reset |
| addr_i | input | 6 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (enables read side effects) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| xact_start_o | output | 1 | One-cycle launch pulse to the engine |
| xact_proto_o | output | 3 | Protocol select |
| xact_last_o | output | 1 | Last-byte flag |
| xact_pec_o | output | 1 | Packet error checking requested |
| xact_cmd_o | output | 8 | Command byte |
| xact_saddr_o | output | 8 | Target address and direction |
| xact_data0_o | output | 8 | Data byte 0 |
| xact_data1_o | output | 8 | Data byte 1 |
| xact_done_i | input | 1 | Engine finished |
| xact_dev_err_i | input | 1 | Engine saw a device error |
| xact_byte_done_i | input | 1 | Engine moved one byte |
| blk_mode_o | output | 1 | Block-buffer mode active |
| blk_wr_o | output | 1 | Block buffer write strobe |
| blk_rd_o | output | 1 | Block buffer read strobe |
| blk_idx_o | output | IDX_W | Block buffer index |
| blk_wdata_o | output | 8 | Block buffer write data |
| blk_rdata_i | input | 8 | Block buffer read data |

## Verification
The bench builds the block with IDX_W set to 3, so the index wraps after eight block accesses and R10's rollover needs only a few register writes. The reset is applied a second time with the strap tied high to reach the other reset value of the auxiliary register. A behavioural model tracks status, deferred-start state and the index, and it is compared against the launch pulse, the interrupt, the block strobes and the index on every clock. This exposes ordering cases such as an engine event meeting a status clear, and a kill arriving after a deferred start.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_CTL = 6'h02;
  localparam logic [5:0] OFS_CMD = 6'h03;
  localparam logic [5:0] OFS_SAD = 6'h04;
  localparam logic [5:0] OFS_D0  = 6'h05;
  localparam logic [5:0] OFS_D1  = 6'h06;
  localparam logic [5:0] OFS_BLK = 6'h07;
  localparam logic [5:0] OFS_AUX = 6'h0D;

  localparam int SB_BUSY  = 0;
  localparam int SB_DEVER = 2;
  localparam int SB_FAIL  = 4;

  // stored control bits (start is never stored)
  typedef struct packed {
    logic       pec;
    logic       last;
    logic [2:0] proto;
    logic       kill;
    logic       ie;
  } ctl_t;
endpackage

// File: rtl/smbh_rst_sync.sv
module smbh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/smbh_status.sv
module smbh_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_en,
  input  logic [7:1] clr_bits,
  input  logic [7:1] set_bits,
  input  logic       busy_set,
  input  logic       busy_clr,
  output logic [7:0] sts_q
);
  logic [7:0] sts_d;
  logic       sts_en;

  always_comb begin
    sts_d[7:1] = (sts_q[7:1] & ~(clr_en ? clr_bits : 7'h00)) | set_bits;
    if (busy_clr)      sts_d[0] = 1'b0;
    else if (busy_set) sts_d[0] = 1'b1;
    else               sts_d[0] = sts_q[0];
    sts_en = clr_en | (|set_bits) | busy_set | busy_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= 8'h00;
    else if (sts_en) sts_q <= sts_d;
  end
endmodule

// File: rtl/smbh_ctrl.sv
module smbh_ctrl import smbh_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] wdata,
  input  logic       sts_rd,
  input  logic       dev_err,
  output ctl_t       ctl_q,
  output logic       start_q,
  output logic       busy_set,
  output logic       busy_clr,
  output logic       fail_set,
  output logic       idx_clr
);
  logic pend_q, pend_d, start_d, go_now, go_late, kill;
  ctl_t ctl_d;

  always_comb begin
    ctl_d    = ctl_wr ? ctl_t'({wdata[7], wdata[5:0]}) : ctl_q;
    kill     = ctl_wr & wdata[1];
    go_now   = ctl_wr & wdata[6] & wdata[0];
    go_late  = sts_rd & pend_q;
    busy_set = ctl_wr & wdata[6] & ~wdata[0];
    busy_clr = kill | go_late;
    fail_set = kill;
    idx_clr  = kill | (ctl_wr & wdata[6]);
    start_d  = (go_now | go_late) & ~dev_err;
    if (kill)          pend_d = 1'b0;
    else if (busy_set) pend_d = 1'b1;
    else if (go_late)  pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_d;
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/smbh_blkidx.sv
module smbh_blkidx #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx_q + 1'b1;
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (clr || inc) idx_q <= idx_d;
  end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs import smbh_pkg::*; #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_blk_i,
  input  logic [5:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o,
  output logic             xact_start_o,
  output logic [2:0]       xact_proto_o,
  output logic             xact_last_o,
  output logic             xact_pec_o,
  output logic [7:0]       xact_cmd_o,
  output logic [7:0]       xact_saddr_o,
  output logic [7:0]       xact_data0_o,
  output logic [7:0]       xact_data1_o,
  input  logic             xact_done_i,
  input  logic             xact_dev_err_i,
  input  logic             xact_byte_done_i,
  output logic             blk_mode_o,
  output logic             blk_wr_o,
  output logic             blk_rd_o,
  output logic [IDX_W-1:0] blk_idx_o,
  output logic [7:0]       blk_wdata_o,
  input  logic [7:0]       blk_rdata_i
);
  logic       rst_q_n;
  logic       sts_wr, sts_rd, ctl_wr, blk_acc;
  logic [7:0] sts_q;
  logic [7:1] set_bits;
  logic       busy_set, busy_clr, fail_set, idx_clr;
  ctl_t       ctl_q;
  logic [7:0] cmd_q, sad_q, d0_q, d1_q, blk_q;
  logic [7:0] cmd_d, sad_d, d0_d, d1_d, blk_d;
  logic [1:0] aux_q, aux_d;

  smbh_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  always_comb begin
    sts_wr   = wr_en_i && (addr_i == OFS_STS);
    sts_rd   = rd_en_i && (addr_i == OFS_STS);
    ctl_wr   = wr_en_i && (addr_i == OFS_CTL);
    blk_wr_o = wr_en_i && (addr_i == OFS_BLK) && aux_q[1];
    blk_rd_o = rd_en_i && (addr_i == OFS_BLK) && aux_q[1];
    blk_acc  = blk_wr_o | blk_rd_o;
    set_bits = {xact_byte_done_i, 2'b00, fail_set, 1'b0, xact_dev_err_i, xact_done_i};
  end

  smbh_status u_sts (
    .clk(clk), .rst_n(rst_q_n), .clr_en(sts_wr), .clr_bits(wdata_i[7:1]),
    .set_bits(set_bits), .busy_set(busy_set), .busy_clr(busy_clr), .sts_q(sts_q)
  );

  smbh_ctrl u_ctl (
    .clk(clk), .rst_n(rst_q_n), .ctl_wr(ctl_wr), .wdata(wdata_i), .sts_rd(sts_rd),
    .dev_err(sts_q[SB_DEVER]), .ctl_q(ctl_q), .start_q(xact_start_o),
    .busy_set(busy_set), .busy_clr(busy_clr), .fail_set(fail_set), .idx_clr(idx_clr)
  );

  smbh_blkidx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_q_n), .clr(idx_clr), .inc(blk_acc), .idx_q(blk_idx_o)
  );

  // plain data registers
  always_comb begin
    cmd_d = (wr_en_i && addr_i == OFS_CMD) ? wdata_i : cmd_q;
    sad_d = (wr_en_i && addr_i == OFS_SAD) ? wdata_i : sad_q;
    d0_d  = (wr_en_i && addr_i == OFS_D0)  ? wdata_i : d0_q;
    d1_d  = (wr_en_i && addr_i == OFS_D1)  ? wdata_i : d1_q;
    blk_d = (wr_en_i && addr_i == OFS_BLK && !aux_q[1]) ? wdata_i : blk_q;
    aux_d = (wr_en_i && addr_i == OFS_AUX) ? wdata_i[1:0] : aux_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cmd_q <= 8'h00;
      sad_q <= 8'h00;
      d0_q  <= 8'h00;
      d1_q  <= 8'h00;
      blk_q <= 8'h00;
      aux_q <= {force_blk_i, 1'b0};
    end else if (wr_en_i) begin
      cmd_q <= cmd_d;
      sad_q <= sad_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
      blk_q <= blk_d;
      aux_q <= aux_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_STS: rdata_o = sts_q;
      OFS_CTL: rdata_o = {3'b000, ctl_q.proto, ctl_q.kill, ctl_q.ie};
      OFS_CMD: rdata_o = cmd_q;
      OFS_SAD: rdata_o = sad_q;
      OFS_D0:  rdata_o = d0_q;
      OFS_D1:  rdata_o = d1_q;
      OFS_BLK: rdata_o = aux_q[1] ? blk_rdata_i : blk_q;
      OFS_AUX: rdata_o = {6'b000000, aux_q};
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_o        = ctl_q.ie & (|sts_q[7:1]);
  assign xact_proto_o = ctl_q.proto;
  assign xact_last_o  = ctl_q.last;
  assign xact_pec_o   = ctl_q.pec | aux_q[0];
  assign xact_cmd_o   = cmd_q;
  assign xact_saddr_o = sad_q;
  assign xact_data0_o = d0_q;
  assign xact_data1_o = d1_q;
  assign blk_mode_o   = aux_q[1];
  assign blk_wdata_o  = wdata_i;
endmodule

// File: rtl/smbh_checker.sv
module smbh_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [5:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       rdata_o,
  input logic             irq_o,
  input logic             xact_start_o,
  input logic [7:0]       sts_q,
  input logic [IDX_W-1:0] blk_idx_o,
  input logic             ctl_ie
);
  logic ctl_w, mapped;
  assign ctl_w  = wr_en_i && (addr_i == 6'h02);
  assign mapped = (addr_i <= 6'h07 && addr_i != 6'h01) || addr_i == 6'h0D;

  // R2: busy survives a status write
  p_busy_keep_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en_i && addr_i == 6'h00 && sts_q[0]) |=> sts_q[0]);

  // R3: unmapped offsets read zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en_i && !mapped) |-> (rdata_o == 8'h00));

  // R4: immediate launch
  p_imm_launch_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_w && wdata_i[6] && wdata_i[0] && !wdata_i[1] && !sts_q[2]) |=> xact_start_o);

  // R5: deferred start raises busy, no launch yet
  p_defer_busy_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_w && wdata_i[6] && !wdata_i[0] && !wdata_i[1]) |=> (sts_q[0] && !xact_start_o));

  // R6: no launch out of a device-error state
  p_no_launch_err_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    xact_start_o |-> !$past(sts_q[2]));

  // R7: kill ends the operation
  p_kill_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_w && wdata_i[1]) |=> (!sts_q[0] && sts_q[4] && blk_idx_o == '0));

  // R8: interrupt masked by enable
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctl_ie |-> !irq_o);
endmodule

bind smbus_host_regs smbh_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .xact_start_o(xact_start_o), .sts_q(sts_q), .blk_idx_o(blk_idx_o),
  .ctl_ie(ctl_q.ie)
);

// File: tb/smbus_host_regs_tb_top.sv
module smbus_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIDX = 3;
  localparam int IMASK = (1 << BIDX) - 1;
  localparam logic [7:0] BUF_BYTE = 8'hA5;

  logic clk = 1'b0;
  logic rst_n, force_blk;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic wr_en, rd_en, irq, xstart, xlast, xpec, dn, er, bd;
  logic [2:0] xproto;
  logic [7:0] xcmd, xsad, xd0, xd1, bwdata;
  logic bmode, bwr, brd;
  logic [BIDX-1:0] bidx;

  int n_chk = 0, n_fail = 0;
  int m_sts, m_ctl, m_cmd, m_sad, m_d0, m_d1, m_blk, m_aux, m_idx, m_pend, m_start;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_host_regs #(.IDX_W(BIDX)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_blk_i(force_blk), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq),
    .xact_start_o(xstart), .xact_proto_o(xproto), .xact_last_o(xlast), .xact_pec_o(xpec),
    .xact_cmd_o(xcmd), .xact_saddr_o(xsad), .xact_data0_o(xd0), .xact_data1_o(xd1),
    .xact_done_i(dn), .xact_dev_err_i(er), .xact_byte_done_i(bd),
    .blk_mode_o(bmode), .blk_wr_o(bwr), .blk_rd_o(brd), .blk_idx_o(bidx),
    .blk_wdata_o(bwdata), .blk_rdata_i(BUF_BYTE)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return m_sts;
      2: return m_ctl & 8'h1F;
      3: return m_cmd;
      4: return m_sad;
      5: return m_d0;
      6: return m_d1;
      7: return (m_aux & 2) ? BUF_BYTE : m_blk;
      13: return m_aux;
      default: return 0;
    endcase
  endfunction

  task automatic model_update(input bit we, input bit re, input int a, input logic [7:0] d,
                              input bit e_dn, input bit e_er, input bit e_bd);
    int s = m_sts;
    int st = 0;
    if (we && a == 0) s &= ~(d & 8'hFE);
    if (e_dn) s |= 8'h02;
    if (e_er) s |= 8'h04;
    if (e_bd) s |= 8'h80;
    if (we && a == 2) begin
      m_ctl = d & 8'hBF;
      if (d[6]) begin
        m_idx = 0;
        if (d[0]) begin
          if ((m_sts & 4) == 0) st = 1;
        end else begin
          s |= 1; m_pend = 1;
        end
      end
      if (d[1]) begin
        s |= 8'h10; s &= ~1; m_pend = 0; m_idx = 0;
      end
    end
    if (re && a == 0 && m_pend == 1) begin
      m_pend = 0; s &= ~1;
      if ((m_sts & 4) == 0) st = 1;
    end
    if (we && a == 3) m_cmd = d;
    if (we && a == 4) m_sad = d;
    if (we && a == 5) m_d0 = d;
    if (we && a == 6) m_d1 = d;
    if (we && a == 13) m_aux = d & 3;
    if ((we || re) && a == 7) begin
      if (m_aux & 2) m_idx = (m_idx + 1) & IMASK;
      else if (we) m_blk = d;
    end
    m_sts = s & 8'hFF;
    m_start = st;
  endtask

  // one bus cycle; compares outputs against the model every clock
  task automatic step(input bit we, input bit re, input int a, input logic [7:0] d,
                      input bit e_dn, input bit e_er, input bit e_bd, output logic [7:0] got);
    int exp_rd;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a[5:0]; wdata = d; dn = e_dn; er = e_er; bd = e_bd;
    #1;
    got = rdata;
    exp_rd = model_read(a);
    chk("R9 blk_wr strobe", bwr, {31'd0, we && a == 7 && (m_aux & 2) != 0});
    chk("R9 blk_rd strobe", brd, {31'd0, re && a == 7 && (m_aux & 2) != 0});
    if (re) chk($sformatf("R3 read data at %0h", a), got, exp_rd);
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; dn = 0; er = 0; bd = 0;
    model_update(we, re, a, d, e_dn, e_er, e_bd);
    chk("R4 launch pulse", xstart, m_start);
    chk("R8 irq", irq, {31'd0, (m_ctl & 1) != 0 && (m_sts & 8'hFE) != 0});
    chk("R10 block index", bidx, m_idx);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] g;
    step(1, 0, a, d, 0, 0, 0, g);
  endtask

  task automatic rd(input string tag, input int a, input logic [7:0] exp);
    logic [7:0] g;
    step(0, 1, a, 8'h00, 0, 0, 0, g);
    chk(tag, g, exp);
  endtask

  task automatic ev(input bit e_dn, input bit e_er, input bit e_bd);
    logic [7:0] g;
    step(0, 0, 0, 8'h00, e_dn, e_er, e_bd, g);
  endtask

  task automatic do_reset(input bit strap);
    force_blk = strap;
    rst_n = 0;
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0; dn = 0; er = 0; bd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_sts = 0; m_ctl = 0; m_cmd = 0; m_sad = 0; m_d0 = 0; m_d1 = 0; m_blk = 0;
    m_aux = strap ? 2 : 0; m_idx = 0; m_pend = 0; m_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(0);
    // R1 reset values
    rd("R1 status after reset", 0, 8'h00);
    rd("R1 control after reset", 2, 8'h00);
    rd("R1 aux after reset", 13, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 index after reset", bidx, 0);

    // R3 readback and masking
    wr(3, 8'h5A); wr(4, 8'hA1); wr(5, 8'h11); wr(6, 8'h22);
    rd("R3 command", 3, 8'h5A);
    rd("R3 address", 4, 8'hA1);
    rd("R3 data0", 5, 8'h11);
    rd("R3 data1", 6, 8'h22);
    wr(2, 8'hBC);
    rd("R3 control mask", 2, 8'h1C);
    chk("R3 protocol out", xproto, 3'h7);
    wr(2, 8'h00);
    rd("R3 unmapped 01", 1, 8'h00);
    rd("R3 unmapped 3F", 6'h3F, 8'h00);
    wr(13, 8'hFF);
    rd("R3 aux mask", 13, 8'h03);
    wr(13, 8'h00);

    // R4 immediate launch, R8 irq, R2 clear
    wr(2, 8'h41);
    chk("R4 pulse after start", xstart, 1);
    rd("R4 busy untouched", 0, 8'h00);
    chk("R4 pulse one cycle", xstart, 0);
    ev(1, 0, 0);
    rd("R2 done sets bit1", 0, 8'h02);
    chk("R8 irq with enable", irq, 1);
    ev(0, 0, 1);
    rd("R2 byte done bit7", 0, 8'h82);
    wr(0, 8'h80);
    rd("R2 partial clear", 0, 8'h02);
    begin
      logic [7:0] g;
      step(1, 0, 0, 8'h02, 1, 0, 0, g);
    end
    rd("R2 set wins over clear", 0, 8'h02);
    wr(0, 8'hFF);
    rd("R2 cleared", 0, 8'h00);
    chk("R8 irq low after clear", irq, 0);

    // R5 deferred start
    wr(2, 8'h40);
    chk("R5 no pulse on deferred", xstart, 0);
    wr(0, 8'h01);
    rd("R5 read returns busy", 0, 8'h01);
    chk("R5 pulse after read", xstart, 1);
    rd("R5 busy cleared", 0, 8'h00);
    ev(1, 0, 0);
    chk("R8 irq masked when disabled", irq, 0);
    wr(0, 8'hFF);

    // R6 launch blocked by device error
    ev(0, 1, 0);
    wr(2, 8'h41);
    chk("R6 no immediate launch", xstart, 0);
    wr(2, 8'h40);
    rd("R6 deferred read value", 0, 8'h05);
    chk("R6 no deferred launch", xstart, 0);
    wr(2, 8'h00);
    wr(0, 8'hFF);
    rd("R6 cleared", 0, 8'h00);

    // R7 kill
    wr(13, 8'h02);
    wr(7, 8'h01); wr(7, 8'h02); wr(7, 8'h03);
    chk("R9 index advanced", bidx, 3);
    wr(2, 8'h40);
    wr(2, 8'h02);
    chk("R7 index zeroed", bidx, 0);
    rd("R7 failed, not busy", 0, 8'h10);
    chk("R7 deferred start cancelled", xstart, 0);
    rd("R7 still failed", 0, 8'h10);
    wr(2, 8'h00);
    wr(0, 8'hFF);

    // R9 block read, R10 wrap and start clear
    rd("R9 block read from buffer", 7, BUF_BYTE);
    chk("R9 index after read", bidx, 1);
    for (int i = 0; i < 8; i++) wr(7, 8'(i));
    chk("R10 index wrapped", bidx, 1);
    wr(2, 8'h41);
    chk("R10 start clears index", bidx, 0);
    ev(1, 0, 0);
    wr(0, 8'hFF);
    wr(2, 8'h00);
    wr(7, 8'h10); wr(7, 8'h11);
    wr(13, 8'h00);
    wr(7, 8'h3C);
    rd("R9 local block byte", 7, 8'h3C);
    chk("R9 index held in byte mode", bidx, 2);

    // R1 strap reset value
    do_reset(1);
    rd("R1 aux with strap", 13, 8'h02);
    chk("R1 block mode out", bmode, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule